// File: doc/BRIEF.md
# 15-bit Color Math Blender

This block mixes a main-screen pixel with a second color operand, one channel at a time. The second operand is either the sub-screen pixel or a stored fixed color. Each of the three 5-bit channels is added or subtracted. The result may then be halved. It is then clamped into the 0..31 range, and a packed 15-bit color leaves the block one clock later.

Math is applied only when the main pixel's source layer has its enable bit set and the window flag does not block it. In all other cases the main color passes through unchanged. The fixed color is loaded through a byte-wide write port. Each byte carries a channel mask and one 5-bit intensity, so a single write can set any subset of the three channels to the same value. Window generation and palette lookup belong to neighbouring blocks.

Top module: `cmath_blend`

## Requirements
- R1: Synchronous active-low reset clears the registered output to 0x0000 and the fixed color to 0. After reset, adding the fixed color returns the main color unchanged.
- R2: When `fix_we` is high, `fix_byte[4:0]` is written into each channel whose mask bit is set: bit 5 selects red, bit 6 green and bit 7 blue. Channels whose mask bit is clear keep their value. A write takes effect from the following cycle.
- R3: Colors pack red in bits 4:0, green in bits 9:5 and blue in bits 14:10. In add mode (`op_sub`=0) each channel is main plus operand, saturated at 31.
- R4: In subtract mode (`op_sub`=1) each channel is main minus operand, clamped at 0.
- R5: With `op_half`=1 in add mode, each channel is the unclamped sum shifted right by one.
- R6: With `op_half`=1 in subtract mode, each channel is the difference shifted right by one. A negative difference still gives 0.
- R7: `use_sub`=1 takes the second operand from `sub_color`. `use_sub`=0 takes it from the fixed color.
- R8: Math applies only when `math_en[src_layer]` is 1. Layer codes 0 to 3 are the backgrounds, 4 is sprites and 5 is backdrop. Codes 6 and 7 never get math. A source without math passes `main_color` through.
- R9: When `win_block`=1, `main_color` passes through unchanged, whatever the other controls are.
- R10: The output shows the result of the inputs from one rising edge earlier. Output bit 15 is always 0, and input bit 15 of both colors is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_color | input | 16 | Main-screen pixel color; bit 15 is ignored |
| sub_color | input | 16 | Sub-screen pixel color; bit 15 is ignored |
| src_layer | input | 3 | Source layer of the main pixel |
| math_en | input | 6 | Per-layer math enable, indexed by layer code |
| win_block | input | 1 | 1 blocks color math for this pixel |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_half | input | 1 | 1 = halve the result |
| use_sub | input | 1 | 1 = sub-screen operand, 0 = fixed color |
| fix_we | input | 1 | Fixed color write strobe |
| fix_byte | input | 8 | Channel mask in bits 7:5 and intensity in bits 4:0 |
| out_color | output | 16 | Blended color, registered; bit 15 is 0 |

## Verification
Directed patterns cover each clamping edge. Adding two channels near 31 separates saturation from wrap-around. Subtracting a larger operand separates clamping at 0 from a negative wrap. Halved sums of 31+31 and 31+30 show that the shift is applied before the clamp, not after it.

Fixed-color writes use single-channel and all-channel masks, which shows that unselected channels are preserved. A sweep over all eight layer codes with a single enable bit separates correct enable indexing from an off-by-one or from codes 6 and 7 leaking through.

Seeded random pixels mix every control combination with window blocking and concurrent fixed writes. This exposes any ordering error between a write and the blend that reads the fixed color.

// File: rtl/cmath_pkg.sv
// Package: shared sizes and source-layer codes for the color math blender.
// Assumes three channels of equal width packed from bit 0 upward (red first).
package cmath_pkg;
    localparam int CH_W_DEF   = 5;
    localparam int NUM_CH_DEF = 3;
    localparam int NUM_SRC_DEF = 6;

    typedef enum logic [2:0] {
        SRC_BG1  = 3'd0,
        SRC_BG2  = 3'd1,
        SRC_BG3  = 3'd2,
        SRC_BG4  = 3'd3,
        SRC_SPR  = 3'd4,
        SRC_BACK = 3'd5
    } src_e;
endpackage

// File: rtl/cmath_fixreg.sv
// Module: fixed color store. Each channel loads the shared intensity when its
// select bit is set during a write strobe. Assumes synchronous active-low reset.
module cmath_fixreg #(
    parameter int CH_W   = cmath_pkg::CH_W_DEF,
    parameter int NUM_CH = cmath_pkg::NUM_CH_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [NUM_CH-1:0]        sel,
    input  logic [CH_W-1:0]          val,
    output logic [NUM_CH*CH_W-1:0]   fix_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Load one channel of the fixed color when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fix_q[c*CH_W +: CH_W] <= '0;
            else if (we && sel[c])
                fix_q[c*CH_W +: CH_W] <= val;
        end
    end
endmodule

// File: rtl/cmath_chan.sv
// Module: one channel of add/subtract, optional halving, then clamp to the
// channel range. Purely combinational; halving acts on the unclamped value.
module cmath_chan #(
    parameter int CH_W = cmath_pkg::CH_W_DEF
) (
    input  logic [CH_W-1:0] a,
    input  logic [CH_W-1:0] b,
    input  logic            do_sub,
    input  logic            do_half,
    output logic [CH_W-1:0] y
);
    localparam int W = CH_W + 2;
    localparam logic signed [W-1:0] SAT = {2'b00, {CH_W{1'b1}}};

    logic signed [W-1:0] a_ext, b_ext, raw, shv;

    // Compute the signed sum or difference, shift it, then clamp.
    always_comb begin
        a_ext = $signed({2'b00, a});
        b_ext = $signed({2'b00, b});
        raw   = do_sub ? (a_ext - b_ext) : (a_ext + b_ext);
        shv   = do_half ? (raw >>> 1) : raw;
        if (shv[W-1])
            y = '0;
        else if (shv > SAT)
            y = SAT[CH_W-1:0];
        else
            y = shv[CH_W-1:0];
    end
endmodule

// File: rtl/cmath_gate.sv
// Module: decides whether color math applies to the current pixel from its
// source layer, the per-layer enables and the window block flag.
// Assumes layer codes at or above NUM_SRC never receive math.
module cmath_gate #(
    parameter int NUM_SRC = cmath_pkg::NUM_SRC_DEF,
    parameter int LAYER_W = 3
) (
    input  logic [LAYER_W-1:0] src_layer,
    input  logic [NUM_SRC-1:0] math_en,
    input  logic               win_block,
    output logic               apply
);
    localparam int PAD = 2 ** LAYER_W;

    logic [PAD-1:0] en_pad;

    // Pad the enable vector so every layer code indexes a defined bit.
    always_comb begin
        en_pad = '0;
        en_pad[NUM_SRC-1:0] = math_en;
        apply  = en_pad[src_layer] && !win_block;
    end
endmodule

// File: rtl/cmath_blend.sv
// Module: color math blender top. Selects the second operand, runs one
// arithmetic lane per channel and registers the result (one-cycle latency).
// Assumes the fixed color write and the blend in the same cycle see the old
// fixed value.
module cmath_blend #(
    parameter int CH_W    = cmath_pkg::CH_W_DEF,
    parameter int NUM_CH  = cmath_pkg::NUM_CH_DEF,
    parameter int NUM_SRC = cmath_pkg::NUM_SRC_DEF,
    parameter int COLOR_W = NUM_CH * CH_W + 1,
    parameter int LAYER_W = $clog2(NUM_SRC),
    parameter int FB_W    = CH_W + NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COLOR_W-1:0] main_color,
    input  logic [COLOR_W-1:0] sub_color,
    input  logic [LAYER_W-1:0] src_layer,
    input  logic [NUM_SRC-1:0] math_en,
    input  logic               win_block,
    input  logic               op_sub,
    input  logic               op_half,
    input  logic               use_sub,
    input  logic               fix_we,
    input  logic [FB_W-1:0]    fix_byte,
    output logic [COLOR_W-1:0] out_color
);
    localparam int PIX_W = NUM_CH * CH_W;

    logic [PIX_W-1:0] fix_color;
    logic [PIX_W-1:0] operand;
    logic [PIX_W-1:0] blended;
    logic             apply;

    cmath_fixreg #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_fix (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fix_we),
        .sel   (fix_byte[FB_W-1:CH_W]),
        .val   (fix_byte[CH_W-1:0]),
        .fix_q (fix_color)
    );

    cmath_gate #(.NUM_SRC(NUM_SRC), .LAYER_W(LAYER_W)) u_gate (
        .src_layer (src_layer),
        .math_en   (math_en),
        .win_block (win_block),
        .apply     (apply)
    );

    // Pick the second operand: sub-screen pixel or fixed color.
    always_comb operand = use_sub ? sub_color[PIX_W-1:0] : fix_color;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        cmath_chan #(.CH_W(CH_W)) u_chan (
            .a       (main_color[c*CH_W +: CH_W]),
            .b       (operand[c*CH_W +: CH_W]),
            .do_sub  (op_sub),
            .do_half (op_half),
            .y       (blended[c*CH_W +: CH_W])
        );
    end

    // Register the blended or passed-through color; unused top bit is zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_color <= '0;
        else
            out_color <= {1'b0, apply ? blended : main_color[PIX_W-1:0]};
    end
endmodule

// File: rtl/cmath_blend_chk.sv
// Module: property checker for the blender, attached by bind below.
// Assumes default packing (three channels from bit 0, top bit unused).
module cmath_blend_chk #(
    parameter int CH_W    = 5,
    parameter int NUM_CH  = 3,
    parameter int NUM_SRC = 6,
    parameter int COLOR_W = 16,
    parameter int LAYER_W = 3,
    parameter int FB_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [COLOR_W-1:0]        main_color,
    input logic [LAYER_W-1:0]        src_layer,
    input logic [NUM_SRC-1:0]        math_en,
    input logic                      win_block,
    input logic                      op_sub,
    input logic                      op_half,
    input logic                      fix_we,
    input logic [FB_W-1:0]           fix_byte,
    input logic [NUM_CH*CH_W-1:0]    fix_q,
    input logic [COLOR_W-1:0]        out_color
);
    localparam int PIX_W = NUM_CH * CH_W;

    function automatic logic all_ge(input logic [PIX_W-1:0] x, input logic [PIX_W-1:0] y);
        logic r = 1'b1;
        for (int c = 0; c < NUM_CH; c++)
            if (x[c*CH_W +: CH_W] < y[c*CH_W +: CH_W]) r = 1'b0;
        return r;
    endfunction

    logic math_on;
    // Independent view of whether math should apply this cycle.
    always_comb math_on = (int'(src_layer) < NUM_SRC) && ((math_en >> src_layer) & 1'b1) && !win_block;

    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_color[COLOR_W-1] == 1'b0); // R10

    AST_WIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        win_block |=> out_color[PIX_W-1:0] == $past(main_color[PIX_W-1:0])); // R9

    AST_LAYER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_layer) >= NUM_SRC) |=> out_color[PIX_W-1:0] == $past(main_color[PIX_W-1:0])); // R8

    AST_FIX_RED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_we && fix_byte[CH_W]) |=> fix_q[CH_W-1:0] == $past(fix_byte[CH_W-1:0])); // R2

    AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_we |=> $stable(fix_q)); // R2

    AST_ADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (math_on && !op_sub && !op_half) |=> all_ge(out_color[PIX_W-1:0], $past(main_color[PIX_W-1:0]))); // R3

    AST_SUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (math_on && op_sub) |=> all_ge($past(main_color[PIX_W-1:0]), out_color[PIX_W-1:0])); // R4
endmodule

bind cmath_blend cmath_blend_chk #(
    .CH_W(CH_W), .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC),
    .COLOR_W(COLOR_W), .LAYER_W(LAYER_W), .FB_W(FB_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .main_color(main_color), .src_layer(src_layer),
    .math_en(math_en), .win_block(win_block), .op_sub(op_sub), .op_half(op_half),
    .fix_we(fix_we), .fix_byte(fix_byte), .fix_q(fix_color), .out_color(out_color)
);

// File: tb/cmath_blend_tb.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random pixels, checked against a
// behavioural model of the requirements.
module cmath_blend_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] main_color = '0, sub_color = '0;
    logic [2:0]  src_layer = '0;
    logic [5:0]  math_en = '0;
    logic        win_block = 1'b0, op_sub = 1'b0, op_half = 1'b0, use_sub = 1'b0;
    logic        fix_we = 1'b0;
    logic [7:0]  fix_byte = '0;
    logic [15:0] out_color;

    int checks = 0;
    int errors = 0;
    logic [14:0] fix_m = '0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    cmath_blend u_dut (
        .clk(clk), .rst_n(rst_n), .main_color(main_color), .sub_color(sub_color),
        .src_layer(src_layer), .math_en(math_en), .win_block(win_block),
        .op_sub(op_sub), .op_half(op_half), .use_sub(use_sub),
        .fix_we(fix_we), .fix_byte(fix_byte), .out_color(out_color)
    );

    function automatic logic [15:0] model(input logic [15:0] m, input logic [15:0] s,
                                          input logic [14:0] fx, input logic [2:0] ly,
                                          input logic [5:0] en, input logic w,
                                          input logic sb, input logic hf, input logic us);
        logic [15:0] r = {1'b0, m[14:0]};
        logic [14:0] b = us ? s[14:0] : fx;
        if (ly <= 3'd5 && en[ly] && !w) begin
            for (int c = 0; c < 3; c++) begin
                int v;
                v = sb ? int'(m[c*5 +: 5]) - int'(b[c*5 +: 5]) : int'(m[c*5 +: 5]) + int'(b[c*5 +: 5]);
                if (hf) v = v >>> 1;
                if (v < 0) v = 0;
                if (v > 31) v = 31;
                r[c*5 +: 5] = v[4:0];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: out_color=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input string tag, input logic [15:0] m, input logic [15:0] s,
                        input logic [2:0] ly, input logic [5:0] en, input logic w,
                        input logic sb, input logic hf, input logic us,
                        input logic fwe, input logic [7:0] fb);
        logic [15:0] exp;
        main_color = m; sub_color = s; src_layer = ly; math_en = en; win_block = w;
        op_sub = sb; op_half = hf; use_sub = us; fix_we = fwe; fix_byte = fb;
        exp = model(m, s, fix_m, ly, en, w, sb, hf, us);
        @(posedge clk);
        @(negedge clk);
        check(tag, out_color, exp);
        if (fwe)
            for (int c = 0; c < 3; c++)
                if (fb[5 + c]) fix_m[c*5 +: 5] = fb[4:0];
        fix_we = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: out_color=%h expected=finish", out_color);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset output", out_color, 16'h0000);
        rst_n = 1'b1;
        // R1: fixed color is zero after reset
        step("R1 fixed zero after reset", 16'h1234, 16'h0, 3'd0, 6'h3F, 0, 0, 0, 0, 0, 8'h00);
        // R2: single and multi channel writes
        step("R2 write red", 16'h0, 16'h0, 3'd0, 6'h00, 0, 0, 0, 0, 1, 8'h3F);
        step("R2 red only", 16'h0, 16'h0, 3'd0, 6'h01, 0, 0, 0, 0, 0, 8'h00);
        step("R2 write green", 16'h0, 16'h0, 3'd0, 6'h00, 0, 0, 0, 0, 1, 8'h4A);
        step("R2 red kept green set", 16'h0, 16'h0, 3'd1, 6'h02, 0, 0, 0, 0, 0, 8'h00);
        step("R2 write all", 16'h0, 16'h0, 3'd0, 6'h00, 0, 0, 0, 0, 1, 8'hE3);
        step("R2 all channels", 16'h0421, 16'h0, 3'd4, 6'h10, 0, 0, 0, 0, 0, 8'h00);
        // R3/R4/R7 saturation and clamp with the sub-screen operand
        step("R3 add saturate", 16'h7BDE, 16'h0C63, 3'd2, 6'h04, 0, 0, 0, 1, 0, 8'h00);
        step("R4 sub clamp", 16'h14A5, 16'h2A94, 3'd3, 6'h08, 0, 1, 0, 1, 0, 8'h00);
        step("R7 sub operand add", 16'h0421, 16'h0842, 3'd5, 6'h20, 0, 0, 0, 1, 0, 8'h00);
        // R5/R6 halving
        step("R5 half 31+31", 16'h7FFF, 16'h7FFF, 3'd0, 6'h01, 0, 0, 1, 1, 0, 8'h00);
        step("R5 half 31+30", 16'h7FFF, 16'h7BDE, 3'd0, 6'h01, 0, 0, 1, 1, 0, 8'h00);
        step("R6 half sub", 16'h5294, 16'h14A5, 3'd0, 6'h01, 0, 1, 1, 1, 0, 8'h00);
        step("R6 half sub negative", 16'h14A5, 16'h5294, 3'd0, 6'h01, 0, 1, 1, 1, 0, 8'h00);
        // R8 layer sweep, one enable bit per code
        for (int l = 0; l < 8; l++) begin
            step("R8 layer enabled", 16'h2108, 16'h0C63, 3'(l), 6'(1 << (l % 6)), 0, 0, 0, 1, 0, 8'h00);
            step("R8 layer disabled", 16'h2108, 16'h0C63, 3'(l), ~6'(1 << (l % 6)) & 6'h3F, 0, 0, 0, 1, 0, 8'h00);
        end
        // R9 window block
        step("R9 window block", 16'h2108, 16'h0C63, 3'd0, 6'h3F, 1, 0, 0, 1, 0, 8'h00);
        // R10 top bit ignored, and latency (output still old before the edge)
        step("R10 top bit", 16'hFFFF, 16'h8000, 3'd1, 6'h3F, 0, 1, 0, 1, 0, 8'h00);
        main_color = 16'h0001; src_layer = 3'd7;
        #1 check("R10 output holds until edge", out_color, 16'h7FFF);
        step("R10 one cycle", 16'h0001, 16'h0, 3'd7, 6'h00, 0, 0, 0, 0, 0, 8'h00);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] m, s;
            logic [2:0] ly;
            logic [5:0] en;
            logic w, sb, hf, us, fwe;
            logic [7:0] fb;
            m = 16'($urandom); s = 16'($urandom); ly = 3'($urandom); en = 6'($urandom);
            w = ($urandom % 4) == 0; sb = 1'($urandom); hf = 1'($urandom); us = 1'($urandom);
            fwe = ($urandom % 4) == 0; fb = 8'($urandom);
            step(sb ? (hf ? "R6 random" : "R4 random") : (hf ? "R5 random" : "R3 random"),
                 m, s, ly, en, w, sb, hf, us, fwe, fb);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule